// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block is an up-counting timer with two compare channels, A and B. Each channel drives an output pin. What the pin does is set by a 2-bit output mode for that channel and by a 3-bit waveform mode. The waveform mode picks one of three counting schemes. Normal mode wraps at all-ones. Clear-on-compare mode (CTC) restarts after the channel A compare value. Fast PWM wraps at either all-ones or the channel A compare value. The output mode then picks how the pin reacts: it can toggle, clear or set on a compare match, or, in fast PWM, produce an inverting or non-inverting pulse train.

Software reaches a control register and the two compare registers through a one-cycle write port and a combinational read port. The top waveform mode bit is a separate input, because it is held elsewhere in the chip. The block reports for each channel whether its pin takes over from ordinary port use. The counter advances by one step on each clock where the count enable is high.

Top module: `cmp_wave_timer`

## Requirements
- R1: A synchronous reset clears the count, both pins, both override flags, the control register and both compare registers. Every read address then returns zero.
- R2: Addresses are: 0 control, 1 compare A, 2 compare B, 3 always reads zero. Control bits 7:6 hold channel A's output mode and bits 5:4 hold channel B's. Bits 1:0 hold the low two waveform mode bits. Bits 3:2 always read zero. A compare address reads back the last value written to it.
- R3: The count changes only on clocks with the count enable high. On such a clock, a count equal to TOP becomes zero and any other count increments. The waveform mode {wave_hi, ctrl[1:0]} sets TOP: 000 gives 0xFF (normal), 010 gives compare A (CTC), 011 gives 0xFF (fast PWM), 111 gives compare A (fast PWM). Any other code behaves like normal mode.
- R4: A channel's override flag is high when its output mode is nonzero. The one exception is fast PWM with output mode 01 and wave_hi = 0, where the flag is low.
- R5: Outside fast PWM, a compare match is an enabled clock on which the count equals the channel's compare value. On a match, output mode 01 toggles the pin, 10 clears it and 11 sets it. No pin changes on a clock with the count enable low.
- R6: In fast PWM, output mode 10 clears the pin on a compare match. It sets the pin on the enabled clock where the count wraps from TOP to zero.
- R7: In fast PWM, output mode 11 sets the pin on a compare match. It clears the pin on the wrap from TOP to zero.
- R8: In fast PWM, output mode 01 toggles the pin on a compare match when wave_hi is 1. It leaves the pin unchanged when wave_hi is 0.
- R9: In fast PWM, when a channel's active compare value equals TOP and its output mode is 10 or 11, the match is ignored. Only the action at the wrap is performed.
- R10: In fast PWM, a written compare value takes effect on the enabled clock where the count wraps at TOP. Outside fast PWM it takes effect from the clock edge of the write.
- R11: With output mode 00 the pin holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable, one step per enabled clock |
| wave_hi | input | 1 | Top waveform mode bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | W | Register read data, combinational |
| count | output | W | Current count |
| oc_a | output | 1 | Channel A compare output pin |
| oc_b | output | 1 | Channel B compare output pin |
| ovr_a | output | 1 | Channel A pin overrides the port |
| ovr_b | output | 1 | Channel B pin overrides the port |

## Verification
The assertions assume that every input holds a known level at each rising edge after reset. They also assume that a write and a mode change land on a clock edge, so that the pin and buffer rules can be judged from the values seen at that edge. The bench changes every input only on the falling clock edge and drops the count enable while it writes registers. Each compare value and mode change therefore starts from a known count, and the bench can count the enabled edges to predict where every match and wrap falls.

// File: rtl/cmp_wave_pkg.sv
package cmp_wave_pkg;

    localparam int NUM_CH = 2;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam int ADDR_CMP0 = 1;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'b00,
        OUT_TOGGLE = 2'b01,
        OUT_CLEAR  = 2'b10,
        OUT_SET    = 2'b11
    } out_mode_e;

    typedef struct packed {
        out_mode_e  mode_a;
        out_mode_e  mode_b;
        logic [1:0] zero;
        logic [1:0] wave_lo;
    } ctrl_t;

    typedef struct packed {
        logic pwm;
        logic top_from_cmp;
    } wave_cfg_t;

    function automatic wave_cfg_t decode_wave(input logic hi, input logic [1:0] lo);
        wave_cfg_t c;
        c.pwm          = (lo == 2'b11);
        c.top_from_cmp = ({hi, lo} == 3'b010) || ({hi, lo} == 3'b111);
        return c;
    endfunction

    function automatic logic pin_override(input out_mode_e m, input logic pwm, input logic hi);
        return (m != OUT_OFF) && !(pwm && (m == OUT_TOGGLE) && !hi);
    endfunction

    // Next pin level from the current level, the mode and the events of this clock.
    function automatic logic next_pin(
        input logic      cur,
        input out_mode_e m,
        input logic      pwm,
        input logic      hi,
        input logic      match,
        input logic      bottom,
        input logic      cmp_is_top
    );
        logic hit;
        logic nxt;
        hit = match;
        if (pwm && m[1] && cmp_is_top) begin
            hit = 1'b0;
        end
        nxt = cur;
        if (!pwm) begin
            unique case (m)
                OUT_TOGGLE: nxt = hit ? ~cur : cur;
                OUT_CLEAR:  nxt = hit ? 1'b0 : cur;
                OUT_SET:    nxt = hit ? 1'b1 : cur;
                default:    nxt = cur;
            endcase
        end else begin
            unique case (m)
                OUT_TOGGLE: nxt = (hi && hit) ? ~cur : cur;
                OUT_CLEAR:  nxt = bottom ? 1'b1 : (hit ? 1'b0 : cur);
                OUT_SET:    nxt = bottom ? 1'b0 : (hit ? 1'b1 : cur);
                default:    nxt = cur;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cmp_wave_regs.sv
module cmp_wave_regs
    import cmp_wave_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [W-1:0]              rd_data,
    input  logic                      pwm,
    input  logic                      reload,
    output ctrl_t                     ctrl,
    output logic [NUM_CH-1:0][W-1:0]  cmp_buf,
    output logic [NUM_CH-1:0][W-1:0]  cmp_act
);

    logic ctrl_sel;
    assign ctrl_sel = wr_en && (wr_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_sel) begin
            ctrl.mode_a  <= out_mode_e'(wr_data[7:6]);
            ctrl.mode_b  <= out_mode_e'(wr_data[5:4]);
            ctrl.zero    <= 2'b00;
            ctrl.wave_lo <= wr_data[1:0];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        logic         sel;
        logic [W-1:0] buf_q;
        logic [W-1:0] act_q;

        assign sel = wr_en && (wr_addr == ADDR_W'(ADDR_CMP0 + c));

        always_ff @(posedge clk) begin
            if (rst) begin
                buf_q <= '0;
                act_q <= '0;
            end else begin
                if (sel) begin
                    buf_q <= wr_data;
                end
                if (!pwm) begin
                    act_q <= sel ? wr_data : buf_q;
                end else if (reload) begin
                    act_q <= buf_q;
                end
            end
        end

        assign cmp_buf[c] = buf_q;
        assign cmp_act[c] = act_q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_data = W'(ctrl);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(ADDR_CMP0 + c)) begin
                rd_data = cmp_buf[c];
            end
        end
    end

endmodule

// File: rtl/cmp_wave_counter.sv
module cmp_wave_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] top,
    output logic [W-1:0] count,
    output logic         wrap
);

    assign wrap = (count == top);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (step) begin
            count <= wrap ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/cmp_wave_channel.sv
module cmp_wave_channel
    import cmp_wave_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] top,
    input  logic         wrap,
    input  out_mode_e    mode,
    input  wave_cfg_t    cfg,
    input  logic         hi,
    output logic         pin,
    output logic         ovr
);

    logic match;
    logic bottom;
    logic cmp_is_top;
    logic pin_d;

    assign match      = step && (count == cmp);
    assign bottom     = step && wrap && cfg.pwm;
    assign cmp_is_top = (cmp == top);

    always_comb begin
        pin_d = next_pin(pin, mode, cfg.pwm, hi, match, bottom, cmp_is_top);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else begin
            pin <= pin_d;
        end
    end

    assign ovr = pin_override(mode, cfg.pwm, hi);

endmodule

// File: rtl/cmp_wave_timer.sv
module cmp_wave_timer
    import cmp_wave_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              wave_hi,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [1:0]        rd_addr,
    output logic [W-1:0]      rd_data,
    output logic [W-1:0]      count,
    output logic              oc_a,
    output logic              oc_b,
    output logic              ovr_a,
    output logic              ovr_b
);

    ctrl_t                     ctrl_q;
    wave_cfg_t                 cfg;
    logic [NUM_CH-1:0][W-1:0]  cmp_buf;
    logic [NUM_CH-1:0][W-1:0]  cmp_act;
    logic [W-1:0]              top_val;
    logic                      wrap;
    logic                      reload;
    out_mode_e                 ch_mode [NUM_CH];
    logic [NUM_CH-1:0]         pin;
    logic [NUM_CH-1:0]         ovr;

    assign cfg     = decode_wave(wave_hi, ctrl_q.wave_lo);
    assign top_val = cfg.top_from_cmp ? cmp_act[0] : '1;
    assign reload  = cnt_en && wrap;

    assign ch_mode[0] = ctrl_q.mode_a;
    assign ch_mode[1] = ctrl_q.mode_b;

    cmp_wave_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm     (cfg.pwm),
        .reload  (reload),
        .ctrl    (ctrl_q),
        .cmp_buf (cmp_buf),
        .cmp_act (cmp_act)
    );

    cmp_wave_counter #(.W(W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .step  (cnt_en),
        .top   (top_val),
        .count (count),
        .wrap  (wrap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cmp_wave_channel #(.W(W)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .step  (cnt_en),
            .count (count),
            .cmp   (cmp_act[c]),
            .top   (top_val),
            .wrap  (wrap),
            .mode  (ch_mode[c]),
            .cfg   (cfg),
            .hi    (wave_hi),
            .pin   (pin[c]),
            .ovr   (ovr[c])
        );
    end

    assign oc_a  = pin[0];
    assign oc_b  = pin[1];
    assign ovr_a = ovr[0];
    assign ovr_b = ovr[1];

endmodule

// File: rtl/cmp_wave_checker.sv
module cmp_wave_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en,
    input logic [W-1:0] count,
    input logic         wrap,
    input logic         pwm,
    input logic [1:0]   mode_a,
    input logic [1:0]   mode_b,
    input logic         oc_a,
    input logic         oc_b,
    input logic         ovr_a,
    input logic         ovr_b,
    input logic [W-1:0] act_a,
    input logic [W-1:0] act_b
);

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !wrap) |=> (count == W'($past(count) + 1'b1)));

    assert_count_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && wrap) |=> (count == '0));

    assert_ovr_off_a_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_a == 2'b00) |-> !ovr_a);

    assert_ovr_off_b_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_b == 2'b00) |-> !ovr_b);

    assert_pin_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> ($stable(oc_a) && $stable(oc_b)));

    assert_bottom_set_R6: assert property (@(posedge clk) disable iff (rst)
        (pwm && cnt_en && wrap && mode_a == 2'b10) |=> oc_a);

    assert_bottom_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (pwm && cnt_en && wrap && mode_b == 2'b11) |=> !oc_b);

    assert_buffer_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (pwm && !(cnt_en && wrap)) |=> ($stable(act_a) && $stable(act_b)));

    assert_pin_off_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_a == 2'b00) |=> $stable(oc_a));

endmodule

bind cmp_wave_timer cmp_wave_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .count  (count),
    .wrap   (wrap),
    .pwm    (cfg.pwm),
    .mode_a (ctrl_q.mode_a),
    .mode_b (ctrl_q.mode_b),
    .oc_a   (oc_a),
    .oc_b   (oc_b),
    .ovr_a  (ovr_a),
    .ovr_b  (ovr_b),
    .act_a  (cmp_act[0]),
    .act_b  (cmp_act[1])
);

// File: tb/cmp_wave_timer_bench.sv
module cmp_wave_timer_bench;

    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic         clk = 1'b0;
    logic         rst;
    logic         cnt_en;
    logic         wave_hi;
    logic         wr_en;
    logic [1:0]   wr_addr;
    logic [W-1:0] wr_data;
    logic [1:0]   rd_addr;
    logic [W-1:0] rd_data;
    logic [W-1:0] count;
    logic         oc_a, oc_b, ovr_a, ovr_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmp_wave_timer #(.W(W)) u_cmp_wave_timer (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .wave_hi (wave_hi),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .count   (count),
        .oc_a    (oc_a),
        .oc_b    (oc_b),
        .ovr_a   (ovr_a),
        .ovr_b   (ovr_b)
    );

    typedef struct packed {
        logic       run;
        logic       hi;
        logic [8:0] arg;
        logic [7:0] data;
        logic       ea;
        logic       eb;
        logic [7:0] ecnt;
        logic [3:0] req;
    } row_t;

    function automatic row_t wr(input logic hi, input logic [1:0] a, input logic [7:0] d);
        row_t r = '0;
        r.hi   = hi;
        r.arg  = 9'(a);
        r.data = d;
        return r;
    endfunction

    function automatic row_t rn(input logic hi, input logic [8:0] n, input logic ea,
                                input logic eb, input logic [7:0] c, input logic [3:0] q);
        row_t r = '0;
        r.run  = 1'b1;
        r.hi   = hi;
        r.arg  = n;
        r.ea   = ea;
        r.eb   = eb;
        r.ecnt = c;
        r.req  = q;
        return r;
    endfunction

    localparam int NROWS = 31;
    localparam row_t TBL [NROWS] = '{
        wr(0, 2'd1, 8'h05),                 // compare A = 5
        wr(0, 2'd2, 8'h03),                 // compare B = 3
        wr(0, 2'd0, 8'h70),                 // normal: A toggle, B set
        rn(0, 9'd4,   0, 1, 8'h04, 4'd5),   // R5 B set at 3
        rn(0, 9'd2,   1, 1, 8'h06, 4'd5),   // R5 A toggles at 5
        rn(0, 9'd256, 0, 1, 8'h06, 4'd5),   // R5 R3 full wrap at 0xFF
        wr(0, 2'd0, 8'hA0),                 // normal: both clear
        rn(0, 9'd256, 0, 0, 8'h06, 4'd5),   // R5 clear on match
        wr(0, 2'd1, 8'h09),                 // R10 immediate outside PWM
        wr(0, 2'd0, 8'h42),                 // CTC, A toggle, B off
        rn(0, 9'd3,   0, 0, 8'h09, 4'd3),   // R3
        rn(0, 9'd1,   1, 0, 8'h00, 4'd3),   // R3 CTC restart, R5 toggle
        rn(0, 9'd10,  0, 0, 8'h00, 4'd3),   // R3 period of ten
        wr(0, 2'd0, 8'hB3),                 // fast PWM 0xFF: A non-inv, B inv
        rn(0, 9'd255, 0, 1, 8'hFF, 4'd7),   // R7 B set at match
        rn(0, 9'd1,   1, 0, 8'h00, 4'd6),   // R6 R7 wrap actions
        rn(0, 9'd4,   1, 1, 8'h04, 4'd7),   // R7
        wr(0, 2'd1, 8'h06),                 // buffered compare A
        rn(0, 9'd4,   1, 1, 8'h08, 4'd10),  // R10 old value still active
        rn(0, 9'd247, 0, 1, 8'hFF, 4'd6),   // R6 clear at old value 9
        rn(0, 9'd1,   1, 0, 8'h00, 4'd6),   // R6 set at wrap
        rn(0, 9'd7,   0, 1, 8'h07, 4'd10),  // R10 new value 6 active
        wr(0, 2'd2, 8'hFF),                 // compare B = TOP
        rn(0, 9'd248, 0, 1, 8'hFF, 4'd10),  // R10
        rn(0, 9'd1,   1, 0, 8'h00, 4'd7),   // R7 clear at wrap
        rn(0, 9'd256, 1, 0, 8'h00, 4'd9),   // R9 match at TOP ignored
        wr(1, 2'd0, 8'h63),                 // fast PWM TOP=A, A toggle, B non-inv
        rn(1, 9'd6,   1, 0, 8'h06, 4'd8),   // R8
        rn(1, 9'd1,   0, 1, 8'h00, 4'd8),   // R8 toggle at match on TOP
        rn(1, 9'd7,   1, 1, 8'h00, 4'd8),   // R8
        rn(0, 9'd256, 1, 1, 8'h00, 4'd8)    // R8 no toggle with wave_hi low, R9 B
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_run(input int n);
        cnt_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(tag, "rd_data", 32'(rd_data), 32'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; cnt_en = 1'b0; wave_hi = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1", "count", 32'(count), 32'h0);
        check("R1", "oc_a", 32'(oc_a), 32'h0);
        check("R1", "oc_b", 32'(oc_b), 32'h0);
        check("R1", "ovr_a", 32'(ovr_a), 32'h0);
        check("R1", "ovr_b", 32'(ovr_b), 32'h0);
        for (int a = 0; a < 4; a++) read_chk("R1", 2'(a), 8'h00);

        // R2 control layout, bits 3:2 read zero
        do_write(2'd0, 8'hFF);
        read_chk("R2", 2'd0, 8'hF3);
        // R4 override flags
        check("R4", "ovr_a", 32'(ovr_a), 32'h1);
        check("R4", "ovr_b", 32'(ovr_b), 32'h1);
        do_write(2'd0, 8'h53);
        check("R4", "ovr_a pwm 01 hi0", 32'(ovr_a), 32'h0);
        check("R4", "ovr_b pwm 01 hi0", 32'(ovr_b), 32'h0);
        wave_hi = 1'b1;
        #1;
        check("R4", "ovr_a pwm 01 hi1", 32'(ovr_a), 32'h1);
        check("R4", "ovr_b pwm 01 hi1", 32'(ovr_b), 32'h1);
        wave_hi = 1'b0;
        do_write(2'd0, 8'h10);
        check("R4", "ovr_a mode 00", 32'(ovr_a), 32'h0);
        check("R4", "ovr_b normal 01", 32'(ovr_b), 32'h1);
        // R2 address map
        do_write(2'd2, 8'h5A);
        read_chk("R2", 2'd2, 8'h5A);
        read_chk("R2", 2'd1, 8'h00);
        read_chk("R2", 2'd3, 8'h00);
        read_chk("R2", 2'd0, 8'h10);

        // R1 reset clears registers
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_chk("R1", 2'd0, 8'h00);
        read_chk("R1", 2'd2, 8'h00);

        for (int i = 0; i < NROWS; i++) begin
            wave_hi = TBL[i].hi;
            if (!TBL[i].run) begin
                do_write(TBL[i].arg[1:0], TBL[i].data);
            end else begin
                do_run(int'(TBL[i].arg));
                check($sformatf("R%0d row %0d", TBL[i].req, i), "count",
                      32'(count), 32'(TBL[i].ecnt));
                check($sformatf("R%0d row %0d", TBL[i].req, i), "oc_a",
                      32'(oc_a), 32'(TBL[i].ea));
                check($sformatf("R%0d row %0d", TBL[i].req, i), "oc_b",
                      32'(oc_b), 32'(TBL[i].eb));
            end
        end

        // R11 mode 00 holds both pins through a full PWM period
        wave_hi = 1'b0;
        do_write(2'd0, 8'h03);
        do_run(256);
        check("R11", "count", 32'(count), 32'h0);
        check("R11", "oc_a", 32'(oc_a), 32'h1);
        check("R11", "oc_b", 32'(oc_b), 32'h1);

        // R3 count holds with enable low
        do_run(3);
        check("R3", "count", 32'(count), 32'h3);
        repeat (5) @(negedge clk);
        check("R3", "count held", 32'(count), 32'h3);

        finish_run();
    end

endmodule